// File: doc/BRIEF.md
# Sticky Floating-Point Exception Flag Accumulator

This block sits beside the arithmetic, conversion and compare units of a floating-point datapath. Each unit reports, in the cycle one of its operations completes, a vector of fine-grained status causes and a tag saying whether the operation was a quiet (non-signalling) compare. The block folds these causes into five sticky exception flags: invalid operation, divide by zero, overflow, underflow and inexact.

Nine separate invalid-operation causes collapse into the single invalid flag. The denormal and rounded causes are informational only and are discarded. For quiet compares, the quiet-NaN invalid cause is masked before it reaches the flags. Software reads the flags through a read-and-clear strobe. The stored value is always visible on the read port. A strobe zeroes the stored value at the next clock edge, except for any causes that arrive in that same cycle.

Top module: `fp_flag_accum`

## Requirements
- R1: While rst_ni is low, and in the first cycle after its release, all five flags read as zero.
- R2: The flag output is ordered with invalid in bit 4, divide-by-zero in bit 3, overflow in bit 2, underflow in bit 1 and inexact in bit 0.
- R3: Any one of these cause bits sets the invalid flag: signalling NaN (bit 6), quiet NaN (bit 7), inf minus inf (bit 8), inf over inf (bit 9), zero over zero (bit 10), inf times zero (bit 11), invalid integer conversion (bit 12), invalid compare (bit 13) and square root of a negative (bit 14).
- R4: The divide-by-zero cause (bit 3) sets the divide-by-zero flag and no other flag.
- R5: The inexact (bit 0), overflow (bit 1) and underflow (bit 2) causes each set only their own flag.
- R6: The denormal (bit 4) and rounded (bit 5) causes leave every flag unchanged.
- R7: Flags are sticky. The causes of each valid operation are ORed into the stored flags, and the cause vector has no effect while op_valid_i is low.
- R8: With rd_clr_i high, the read port shows the accumulated flags in that cycle, and after the next clock edge the stored flags are zero when no operation completed in that cycle.
- R9: When op_quiet_cmp_i is high, the quiet-NaN cause does not set the invalid flag.
- R10: When op_quiet_cmp_i is low, the quiet-NaN cause sets the invalid flag. The quiet tag does not mask any other invalid cause.
- R11: When an operation completes in the same cycle as a read-and-clear, the read shows the old flags, and after the edge the stored flags equal exactly that operation's flag contributions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | An operation completes in this cycle |
| op_cause_i | input | 15 | Fine-grained status causes of the completing operation |
| op_quiet_cmp_i | input | 1 | The completing operation is a quiet compare |
| rd_clr_i | input | 1 | Read-and-clear strobe |
| rd_flags_o | output | 5 | Accumulated sticky flags |

## Verification
The bench steps through each invalid cause one at a time. A mapper that dropped any one of the nine causes, or sent a cause to the wrong flag position, would leave a flag clear or set the wrong bit. It presents the denormal and rounded causes, alone and together with a low valid. A design that leaked either of them would raise a flag that should not be there. The quiet-NaN cause is driven with the quiet tag high and with it low, and a signalling NaN is driven under the quiet tag. This catches masking that is missing, masking that is applied the wrong way round, and masking that is too broad. Finally, a cause arrives in the same cycle as a clear. A design that gave the clear priority would lose that cause, and one that merged the two would keep flags from before the read.

// File: rtl/fp_flag_pkg.sv
package fp_flag_pkg;
  localparam int CAUSE_W = 15;
  localparam int FLAG_W  = 5;

  // cause vector bit positions
  localparam int C_NX       = 0;
  localparam int C_OF       = 1;
  localparam int C_UF       = 2;
  localparam int C_DZ       = 3;
  localparam int C_DENORM   = 4;
  localparam int C_ROUNDED  = 5;
  localparam int C_SNAN     = 6;
  localparam int C_QNAN     = 7;
  localparam int C_ISI      = 8;
  localparam int C_IDI      = 9;
  localparam int C_ZDZ      = 10;
  localparam int C_IMZ      = 11;
  localparam int C_CVI      = 12;
  localparam int C_CMP      = 13;
  localparam int C_SQRT     = 14;
  localparam int C_INV_LO   = C_SNAN;
  localparam int C_INV_HI   = C_SQRT;

  // flag output bit positions
  localparam int F_NX = 0;
  localparam int F_UF = 1;
  localparam int F_OF = 2;
  localparam int F_DZ = 3;
  localparam int F_NV = 4;

  typedef logic [CAUSE_W-1:0] cause_t;
  typedef logic [FLAG_W-1:0]  flags_t;

  localparam cause_t INFO_MASK = cause_t'((1 << C_DENORM) | (1 << C_ROUNDED));
endpackage

// File: rtl/fp_cause_map.sv
module fp_cause_map
  import fp_flag_pkg::*;
(
  input  cause_t cause_i,
  input  logic   quiet_cmp_i,
  output flags_t contrib_o
);
  localparam int NUM_INV = C_INV_HI - C_INV_LO + 1;

  logic [NUM_INV-1:0] inv_hits;

  // one hit per invalid cause; quiet NaN masked for quiet compares
  for (genvar g = 0; g < NUM_INV; g++) begin : g_inv
    if (C_INV_LO + g == C_QNAN) begin : g_qnan
      assign inv_hits[g] = cause_i[C_INV_LO + g] & ~quiet_cmp_i;
    end else begin : g_other
      assign inv_hits[g] = cause_i[C_INV_LO + g];
    end
  end

  always_comb begin
    contrib_o       = '0;
    contrib_o[F_NV] = |inv_hits;
    contrib_o[F_DZ] = cause_i[C_DZ];
    contrib_o[F_OF] = cause_i[C_OF];
    contrib_o[F_UF] = cause_i[C_UF];
    contrib_o[F_NX] = cause_i[C_NX];
  end
endmodule

// File: rtl/fp_sticky_bank.sv
module fp_sticky_bank #(
  parameter int WIDTH = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_vld_i,
  input  logic [WIDTH-1:0] set_i,
  input  logic             clr_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic set_b;
    assign set_b = set_vld_i & set_i[b];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    q_o[b] <= 1'b0;
      else if (clr_i) q_o[b] <= set_b;          // clear loses to same-cycle set
      else            q_o[b] <= q_o[b] | set_b;
    end
  end
endmodule

// File: rtl/fp_flag_accum.sv
module fp_flag_accum
  import fp_flag_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                op_valid_i,
  input  logic [CAUSE_W-1:0]  op_cause_i,
  input  logic                op_quiet_cmp_i,
  input  logic                rd_clr_i,
  output logic [FLAG_W-1:0]   rd_flags_o
);
  flags_t contrib;
  flags_t flags_q;

  fp_cause_map u_map (
    .cause_i     (op_cause_i),
    .quiet_cmp_i (op_quiet_cmp_i),
    .contrib_o   (contrib)
  );

  fp_sticky_bank #(.WIDTH(FLAG_W)) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_vld_i (op_valid_i),
    .set_i     (contrib),
    .clr_i     (rd_clr_i),
    .q_o       (flags_q)
  );

  assign rd_flags_o = flags_q;

  assert_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_clr_i |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  assert_info_ignored_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_clr_i && (!op_valid_i || ((op_cause_i & ~INFO_MASK) == '0)))
      |=> flags_q == $past(flags_q));

  assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_clr_i && !op_valid_i) |=> flags_q == '0);

  assert_quiet_mask_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_quiet_cmp_i && !rd_clr_i && op_cause_i == cause_t'(1 << C_QNAN))
      |=> flags_q == $past(flags_q));

  assert_div0_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_cause_i[C_DZ]) |=> flags_q[F_DZ]);

  assert_invalid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && op_cause_i[C_ZDZ]) |=> flags_q[F_NV]);
endmodule

// File: tb/fp_flag_accum_tb.sv
module fp_flag_accum_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [14:0] op_cause = '0;
  logic        op_quiet = 1'b0;
  logic        rd_clr = 1'b0;
  logic [4:0]  rd_flags;

  int checks = 0;
  int errors = 0;
  logic [4:0] ref_flags = '0;
  bit done = 0;

  always #4 clk = ~clk;

  fp_flag_accum dut_i (
    .clk_i(clk), .rst_ni(rst_n), .op_valid_i(op_valid), .op_cause_i(op_cause),
    .op_quiet_cmp_i(op_quiet), .rd_clr_i(rd_clr), .rd_flags_o(rd_flags)
  );

  // requirement-level model: {nv,dz,of,uf,nx}
  function automatic logic [4:0] model_contrib(logic [14:0] c, logic q);
    logic nv = 1'b0;
    for (int i = 6; i <= 14; i++)
      if (c[i] && !(i == 7 && q)) nv = 1'b1;
    return {nv, c[3], c[1], c[2], c[0]};
  endfunction

  task automatic check(string req, logic [4:0] exp);
    checks++;
    if (rd_flags !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", req, rd_flags, exp);
    end
  endtask

  // drive one cycle; pre-check read value, post-check stored state
  task automatic step(string req, logic v, logic [14:0] c, logic q, logic clr);
    @(negedge clk);
    op_valid = v; op_cause = c; op_quiet = q; rd_clr = clr;
    #1 check(req, ref_flags);
    @(posedge clk);
    if (clr) ref_flags = v ? model_contrib(c, q) : 5'b0;
    else if (v) ref_flags = ref_flags | model_contrib(c, q);
    #1 check(req, ref_flags);
    @(negedge clk);
    op_valid = 0; op_cause = '0; op_quiet = 0; rd_clr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 check("R1 in reset", 5'b0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1 check("R1 after release", 5'b0);

    // R3: each invalid cause alone -> bit 4
    for (int i = 6; i <= 14; i++) begin
      step("R3 invalid cause", 1, 15'(1 << i), 0, 0);
      check("R3 R2 invalid at bit4", 5'b10000);
      step("R8 clear", 0, '0, 0, 1);
    end
    step("R4 div0", 1, 15'h0008, 0, 0);
    check("R4 R2 div0 at bit3", 5'b01000);
    step("R8 clear", 0, '0, 0, 1);
    step("R5 overflow", 1, 15'h0002, 0, 0);
    check("R5 R2 overflow at bit2", 5'b00100);
    step("R8 clear", 0, '0, 0, 1);
    step("R5 underflow", 1, 15'h0004, 0, 0);
    check("R5 R2 underflow at bit1", 5'b00010);
    step("R8 clear", 0, '0, 0, 1);
    step("R5 inexact", 1, 15'h0001, 0, 0);
    check("R5 R2 inexact at bit0", 5'b00001);
    step("R8 clear", 0, '0, 0, 1);

    // R6: informational causes
    step("R6 denormal", 1, 15'h0010, 0, 0);
    step("R6 rounded", 1, 15'h0020, 0, 0);
    step("R6 both", 1, 15'h0030, 1, 0);
    check("R6 no flags", 5'b0);

    // R7: accumulation and valid gating
    step("R7 invalid-valid low", 0, 15'h7FFF, 0, 0);
    check("R7 valid low ignored", 5'b0);
    step("R7 accumulate nx", 1, 15'h0001, 0, 0);
    step("R7 accumulate of", 1, 15'h0002, 0, 0);
    step("R7 accumulate dz", 1, 15'h0008, 0, 0);
    step("R7 hold", 0, '0, 0, 0);
    check("R7 sticky", 5'b01101);
    step("R8 read-and-clear", 0, '0, 0, 1);
    check("R8 zero after clear", 5'b0);

    // R9/R10: quiet compare masking
    step("R9 quiet qnan", 1, 15'h0080, 1, 0);
    check("R9 masked", 5'b0);
    step("R10 signalling qnan", 1, 15'h0080, 0, 0);
    check("R10 kept", 5'b10000);
    step("R8 clear", 0, '0, 0, 1);
    step("R10 quiet snan", 1, 15'h0040, 1, 0);
    check("R10 snan not masked", 5'b10000);
    step("R10 quiet cmp cause", 1, 15'h2080, 1, 0);
    step("R8 clear", 0, '0, 0, 1);

    // R11: op with clear in the same cycle
    step("R11 preload", 1, 15'h0005, 0, 0);
    step("R11 op during clear", 1, 15'h0008, 0, 1);
    check("R11 only new causes", 5'b01000);
    step("R11 quiet qnan during clear", 1, 15'h0080, 1, 1);
    check("R11 masked during clear", 5'b0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule